// File: doc/BRIEF.md
# Conversion Queue Status Flag Unit

This block holds the status flags for a conversion sequencer that runs two command queues. Each queue is a list of conversion command words. For each queue the unit keeps three flags:

- a completion flag, raised when the last command of the queue has been converted and its result stored;
- a pause flag, raised when a command carrying a pause mark has been converted and stored;
- a trigger-overrun flag, raised when a trigger arrives that the queue did not expect.

Queue 0 has two extra sources of events. It can run with an external gate, and a gate that closes early raises its pause flag. It can also run in gated continuous scan, where reaching end-of-queue a second time raises its overrun flag.

Software reads all six flags through one 16-bit status word. A flag is cleared by a two-step handshake: software must first read the flag as 1, then write a 0 to its bit position. Writing a 1 never changes a flag. The completion flag and the pause flag each drive a per-queue interrupt request, gated by a per-queue enable. The flags are set whether or not their interrupt is enabled, so software can also poll them.

Top module: `qseq_flag_unit`

## Requirements
- R1: After reset every flag is 0, `rd_data` reads 0 and both `irq` bits are 0.
- R2: When `conv_done[q]` and `last_cmd[q]` are both high at a clock edge, the completion flag of queue q is set from that edge on. It reads at `rd_data` bit q (bit 0 or bit 1). This happens whatever the interrupt enables hold.
- R3: When `conv_done[q]` and `pause_cmd[q]` are both high at a clock edge, the pause flag of queue q is set. It reads at `rd_data` bit 4+q.
- R4: When `gated_mode` and `gate_early_close` are both high at an edge, the pause flag of queue 0 (bit 4) is set. While `gated_mode` is low, `gate_early_close` has no effect.
- R5: When `trig[q]` is high while `q_active[q]` is high, the overrun flag of queue q is set. It reads at `rd_data` bit 8+q. A trigger while the queue is inactive has no effect.
- R6: An end-of-queue event is `conv_done[0]` and `last_cmd[0]` high together. While `gated_cont` and `q_active[0]` are both high, the second end-of-queue event sets the overrun flag of queue 0 (bit 8). The first such event does not set it. Dropping either signal for one cycle restarts the count.
- R7: `irq[q]` is high exactly when (completion flag q AND `cmp_ie[q]`) OR (pause flag q AND `pau_ie[q]`). It follows the flags and enables without a register stage.
- R8: A flag holds its value until it is cleared by reset or by a write. The write clears it only if `wr_data` has a 0 at the flag's bit and a read (`rd_en`) since the last write returned that flag as 1. Writing a 1 leaves the flag unchanged.
- R9: Any write disarms all flags. After a write, a further 0-write clears nothing until a new read has returned the flag as 1.
- R10: A flag read as 0 cannot be cleared by a later 0-write even if it has been set in the meantime. When a hardware set and a valid software clear hit the same edge, the flag stays set.
- R11: Status bits other than 0, 1, 4, 5, 8 and 9 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| conv_done | input | 2 | Per queue: a conversion result was stored this cycle |
| last_cmd | input | 2 | Per queue: the current command is the last of the queue |
| pause_cmd | input | 2 | Per queue: the current command carries a pause mark |
| trig | input | 2 | Per queue: a trigger event occurred this cycle |
| q_active | input | 2 | Per queue: the queue is active |
| gated_mode | input | 1 | Queue 0 runs with an external gate |
| gate_early_close | input | 1 | Queue 0 gate closed before end-of-queue (strobe) |
| gated_cont | input | 1 | Queue 0 runs in gated continuous scan |
| cmp_ie | input | 2 | Per queue completion-interrupt enable |
| pau_ie | input | 2 | Per queue pause-interrupt enable |
| rd_en | input | 1 | Status read strobe; arms each flag that reads as 1 |
| wr_en | input | 1 | Status write strobe |
| wr_data | input | 16 | Write data; a 0 at an armed flag's bit clears it |
| rd_data | output | 16 | Status word |
| irq | output | 2 | Per queue interrupt request |

## Verification
The assertions assume that the event inputs are one-cycle strobes, free of X after reset, and that `rd_en` and `wr_en` never arrive in the same cycle. The sticky-flag property assumes that only a write can clear a flag. The quiet-overrun property for queue 1 assumes that a trigger is the only way its overrun flag can be set. The bench drives each strobe for exactly one cycle from the falling edge and keeps reads and writes in separate cycles. It leaves `gated_cont` low except in the gated-scan test, so no extra set source interferes with the other checks.

// File: rtl/qseq_flag_pkg.sv
package qseq_flag_pkg;

    // Distance between the start of one flag field and the next in the status word.
    localparam int FIELD_STRIDE = 4;

    typedef enum logic [1:0] {
        FK_CMP = 2'd0,
        FK_PAU = 2'd1,
        FK_OVR = 2'd2
    } flag_kind_e;

    localparam int NUM_KINDS = 3;

    typedef struct packed {
        logic flag;
        logic armed;
    } flag_cell_t;

    function automatic int field_pos(input int kind, input int q);
        return kind * FIELD_STRIDE + q;
    endfunction

endpackage

// File: rtl/qseq_flag_cell.sv
module qseq_flag_cell
    import qseq_flag_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hw_set,
    input  logic sw_read,
    input  logic sw_write,
    input  logic sw_bit,
    output logic flag_o
);

    flag_cell_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (sw_read) begin
            st_d.armed = st_q.flag;
        end
        if (sw_write) begin
            if (!sw_bit && st_q.armed) begin
                st_d.flag = 1'b0;
            end
            st_d.armed = 1'b0;
        end
        // A hardware set wins over a software clear in the same cycle.
        if (hw_set) begin
            st_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag_o = st_q.flag;

endmodule

// File: rtl/qseq_set_logic.sv
module qseq_set_logic #(
    parameter int NUM_Q = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NUM_Q-1:0] conv_done,
    input  logic [NUM_Q-1:0] last_cmd,
    input  logic [NUM_Q-1:0] pause_cmd,
    input  logic [NUM_Q-1:0] trig,
    input  logic [NUM_Q-1:0] q_active,
    input  logic             gated_mode,
    input  logic             gate_early_close,
    input  logic             gated_cont,
    output logic [NUM_Q-1:0] set_cmp,
    output logic [NUM_Q-1:0] set_pau,
    output logic [NUM_Q-1:0] set_ovr
);

    typedef struct packed {
        logic eoq_seen;
    } scan_state_t;

    scan_state_t sc_d, sc_q;
    logic [NUM_Q-1:0] eoq;
    logic             scan_on;
    logic             second_eoq;

    always_comb begin
        eoq        = conv_done & last_cmd;
        scan_on    = gated_cont & q_active[0];
        second_eoq = scan_on & eoq[0] & sc_q.eoq_seen;

        sc_d = sc_q;
        if (!scan_on) begin
            sc_d.eoq_seen = 1'b0;
        end else if (eoq[0]) begin
            sc_d.eoq_seen = 1'b1;
        end

        set_cmp    = eoq;
        set_pau    = conv_done & pause_cmd;
        set_pau[0] = set_pau[0] | (gated_mode & gate_early_close);
        set_ovr    = trig & q_active;
        set_ovr[0] = set_ovr[0] | second_eoq;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sc_q <= '0;
        end else begin
            sc_q <= sc_d;
        end
    end

endmodule

// File: rtl/qseq_flag_unit.sv
module qseq_flag_unit
    import qseq_flag_pkg::*;
#(
    parameter int NUM_Q = 2,
    parameter int REG_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NUM_Q-1:0] conv_done,
    input  logic [NUM_Q-1:0] last_cmd,
    input  logic [NUM_Q-1:0] pause_cmd,
    input  logic [NUM_Q-1:0] trig,
    input  logic [NUM_Q-1:0] q_active,
    input  logic             gated_mode,
    input  logic             gate_early_close,
    input  logic             gated_cont,
    input  logic [NUM_Q-1:0] cmp_ie,
    input  logic [NUM_Q-1:0] pau_ie,
    input  logic             rd_en,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    output logic [NUM_Q-1:0] irq
);

    // NUM_Q must not exceed FIELD_STRIDE, and REG_W must hold the last field.
    localparam int NFLAG = NUM_KINDS * NUM_Q;

    logic [NUM_KINDS-1:0][NUM_Q-1:0] set_vec;
    logic [NFLAG-1:0]                flag_flat;

    qseq_set_logic #(.NUM_Q(NUM_Q)) i_set (
        .clk              (clk),
        .rst_n            (rst_n),
        .conv_done        (conv_done),
        .last_cmd         (last_cmd),
        .pause_cmd        (pause_cmd),
        .trig             (trig),
        .q_active         (q_active),
        .gated_mode       (gated_mode),
        .gate_early_close (gate_early_close),
        .gated_cont       (gated_cont),
        .set_cmp          (set_vec[FK_CMP]),
        .set_pau          (set_vec[FK_PAU]),
        .set_ovr          (set_vec[FK_OVR])
    );

    for (genvar k = 0; k < NUM_KINDS; k++) begin : g_kind
        for (genvar q = 0; q < NUM_Q; q++) begin : g_q
            localparam int POS = k * FIELD_STRIDE + q;
            qseq_flag_cell i_cell (
                .clk      (clk),
                .rst_n    (rst_n),
                .hw_set   (set_vec[k][q]),
                .sw_read  (rd_en),
                .sw_write (wr_en),
                .sw_bit   (wr_data[POS]),
                .flag_o   (flag_flat[k*NUM_Q+q])
            );
        end
    end

    always_comb begin
        rd_data = '0;
        for (int k = 0; k < NUM_KINDS; k++) begin
            for (int q = 0; q < NUM_Q; q++) begin
                rd_data[field_pos(k, q)] = flag_flat[k*NUM_Q+q];
            end
        end
    end

    always_comb begin
        for (int q = 0; q < NUM_Q; q++) begin
            irq[q] = (flag_flat[int'(FK_CMP)*NUM_Q+q] & cmp_ie[q])
                   | (flag_flat[int'(FK_PAU)*NUM_Q+q] & pau_ie[q]);
        end
    end

endmodule

// File: rtl/qseq_flag_checker.sv
module qseq_flag_checker
    import qseq_flag_pkg::*;
#(
    parameter int NUM_Q = 2,
    parameter int REG_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NUM_Q-1:0] conv_done,
    input logic [NUM_Q-1:0] last_cmd,
    input logic [NUM_Q-1:0] pause_cmd,
    input logic [NUM_Q-1:0] trig,
    input logic [NUM_Q-1:0] q_active,
    input logic [NUM_Q-1:0] cmp_ie,
    input logic [NUM_Q-1:0] pau_ie,
    input logic             wr_en,
    input logic [REG_W-1:0] rd_data,
    input logic [NUM_Q-1:0] irq
);

    for (genvar q = 0; q < NUM_Q; q++) begin : g_chk
        localparam int CP = q;
        localparam int PP = FIELD_STRIDE + q;
        localparam int OP = 2 * FIELD_STRIDE + q;

        // R2
        cmp_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (conv_done[q] && last_cmd[q]) |=> rd_data[CP]);

        // R3
        pau_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (conv_done[q] && pause_cmd[q]) |=> rd_data[PP]);

        // R5
        ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (trig[q] && q_active[q]) |=> rd_data[OP]);

        // R7
        irq_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
            irq[q] == ((rd_data[CP] && cmp_ie[q]) || (rd_data[PP] && pau_ie[q])));

        // R8
        sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_data[CP] && !wr_en) |=> rd_data[CP]);

        if (q > 0) begin : g_quiet
            // R5
            ovr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !(trig[q] && q_active[q]) |=> !$rose(rd_data[OP]));
        end
    end

endmodule

bind qseq_flag_unit qseq_flag_checker #(.NUM_Q(NUM_Q), .REG_W(REG_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .conv_done (conv_done),
    .last_cmd  (last_cmd),
    .pause_cmd (pause_cmd),
    .trig      (trig),
    .q_active  (q_active),
    .cmp_ie    (cmp_ie),
    .pau_ie    (pau_ie),
    .wr_en     (wr_en),
    .rd_data   (rd_data),
    .irq       (irq)
);

// File: tb/test_qseq_flag_unit.sv
module test_qseq_flag_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  conv_done = '0, last_cmd = '0, pause_cmd = '0, trig = '0, q_active = '0;
    logic        gated_mode = 1'b0, gate_early_close = 1'b0, gated_cont = 1'b0;
    logic [1:0]  cmp_ie = '0, pau_ie = '0;
    logic        rd_en = 1'b0, wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic [1:0]  irq;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    qseq_flag_unit i_qseq_flag_unit (
        .clk(clk), .rst_n(rst_n), .conv_done(conv_done), .last_cmd(last_cmd),
        .pause_cmd(pause_cmd), .trig(trig), .q_active(q_active),
        .gated_mode(gated_mode), .gate_early_close(gate_early_close),
        .gated_cont(gated_cont), .cmp_ie(cmp_ie), .pau_ie(pau_ie),
        .rd_en(rd_en), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .irq(irq)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic do_read();
        rd_en = 1'b1; tick(); rd_en = 1'b0;
    endtask

    task automatic do_write(input logic [15:0] v);
        wr_en = 1'b1; wr_data = v; tick(); wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic clear_all();
        do_read();
        do_write(16'h0000);
    endtask

    task automatic eoq0();
        conv_done[0] = 1'b1; last_cmd[0] = 1'b1; tick();
        conv_done = '0; last_cmd = '0;
    endtask

    initial begin
        repeat (3) tick();
        // R1
        check("R1 status after reset", rd_data, 16'h0000);
        check("R1 irq after reset", {14'd0, irq}, 16'h0000);
        rst_n = 1'b1;
        tick();

        // R2 R3 R7 R11: sweep of event combinations and enable patterns.
        for (int q = 0; q < 2; q++) begin
            for (int c = 0; c < 8; c++) begin
                logic cd, lc, pc, ecmp, epau;
                logic [15:0] exp;
                cd = c[0]; lc = c[1]; pc = c[2];
                clear_all();
                conv_done[q] = cd; last_cmd[q] = lc; pause_cmd[q] = pc;
                tick();
                conv_done = '0; last_cmd = '0; pause_cmd = '0;
                ecmp = cd & lc;
                epau = cd & pc;
                exp = '0;
                exp[q] = ecmp;
                exp[4+q] = epau;
                check("R2/R3/R11 flags from events", rd_data, exp);
                for (int e = 0; e < 4; e++) begin
                    logic [1:0] ei;
                    cmp_ie = '0; pau_ie = '0;
                    cmp_ie[q] = e[0]; pau_ie[q] = e[1];
                    #1;
                    ei = '0;
                    ei[q] = (ecmp & e[0]) | (epau & e[1]);
                    check("R7 irq mapping", {14'd0, irq}, {14'd0, ei});
                end
                cmp_ie = '0; pau_ie = '0;
            end
        end

        // R4: early gate close only counts in gated mode.
        clear_all();
        gate_early_close = 1'b1; tick(); gate_early_close = 1'b0;
        check("R4 early close ignored outside gated mode", rd_data, 16'h0000);
        gated_mode = 1'b1; gate_early_close = 1'b1; tick();
        gate_early_close = 1'b0; gated_mode = 1'b0;
        check("R4 early close sets pause 0", rd_data, 16'h0010);

        // R5: trigger overrun only while active.
        for (int q = 0; q < 2; q++) begin
            for (int a = 0; a < 2; a++) begin
                logic [15:0] exp;
                clear_all();
                q_active[q] = a[0]; trig[q] = 1'b1; tick();
                trig = '0; q_active = '0;
                exp = '0;
                exp[8+q] = a[0];
                check("R5 trigger overrun", rd_data, exp);
            end
        end

        // R6: second end-of-queue in gated continuous scan.
        clear_all();
        gated_cont = 1'b1; q_active[0] = 1'b1;
        eoq0();
        check("R6 first end-of-queue, no overrun", rd_data, 16'h0001);
        eoq0();
        check("R6 second end-of-queue sets overrun", rd_data, 16'h0101);
        clear_all();
        gated_cont = 1'b0; tick(); gated_cont = 1'b1;
        eoq0();
        check("R6 count restarts after scan drop", rd_data, 16'h0001);
        gated_cont = 1'b0; q_active = '0;

        // R8: clear handshake.
        clear_all();
        eoq0();
        do_write(16'h0000);
        check("R8 write 0 without read keeps flag", rd_data, 16'h0001);
        do_read();
        do_write(16'hFFFF);
        check("R8 write 1 leaves flag", rd_data, 16'h0001);
        do_read();
        do_write(16'h0000);
        check("R8 read-then-write-0 clears", rd_data, 16'h0000);

        // R9: any write disarms.
        eoq0();
        do_read();
        do_write(16'hFFFF);
        do_write(16'h0000);
        check("R9 disarmed after write", rd_data, 16'h0001);

        // R10: read as 0 then set; and set beats clear.
        clear_all();
        do_read();
        eoq0();
        do_write(16'h0000);
        check("R10 flag read as 0 not cleared", rd_data, 16'h0001);
        do_read();
        wr_en = 1'b1; wr_data = '0; conv_done[0] = 1'b1; last_cmd[0] = 1'b1;
        tick();
        wr_en = 1'b0; conv_done = '0; last_cmd = '0;
        check("R10 set wins over clear", rd_data, 16'h0001);
        clear_all();
        check("R8 final clear", rd_data, 16'h0000);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule